// File: doc/BRIEF.md
# Synchronous Serial Clock Output Generator

This block produces the serial clock that travels with transmitted data when a serial transmitter runs in synchronous mode. It sits beside a shift-register transmitter. It follows the transmitter's bit-start strobes and bit-index signal, and it uses a bit-rate tick that runs at twice the bit rate to time each half of a bit. For every data bit it emits exactly one clock pulse: one half-period away from the idle level and one half-period at it. It emits nothing for the start bit or the stop bit.

The idle level, the edge placement within a bit, whether the final data bit gets a pulse, and the word length (8 or 9 data bits) all come from configuration inputs. These inputs are captured while the transmitter is disabled and frozen while it is enabled, so a frame never sees a setting change halfway through. A one-cycle frame-done strobe marks the end of the last data bit of each frame, whether or not that bit's pulse was suppressed.

Top module: `sync_clk_gen`

## Requirements
- R1: `sclk_oe` equals `clk_en` at all times; while `clk_en` is 0, `sclk` stays at the idle level and no pulse appears.
- R2: The idle level is low when the polarity select is 0 and high when it is 1; `sclk` is at the idle level whenever no data bit is being clocked.
- R3: With phase select 0, `sclk` leaves the idle level on the half tick at the centre of a data bit and returns on the half tick that ends the bit.
- R4: With phase select 1, `sclk` leaves the idle level on the half tick that starts a data bit (the one carrying `bit_go`) and returns on the centre half tick.
- R5: Only bits with index 1..WL are clocked; index 0 (start bit) and index WL+1 (stop bit) produce no pulse.
- R6: With the last-pulse select at 0, the data bit with index WL produces no pulse; with it at 1, that bit is clocked like the others.
- R7: WL is 8 when the word-length select is 0 and 9 when it is 1.
- R8: While `tx_enable` is 1, the polarity, phase, last-pulse and word-length settings keep the values they had on the cycle before `tx_enable` rose, and input changes are ignored. While `tx_enable` is 0, `sclk` takes the new idle level one cycle after the polarity input changes.
- R9: `frame_done` is high for exactly the one cycle after the half tick that ends data bit WL, whether or not that bit's pulse was suppressed.
- R10: During reset, `sclk` takes the idle level given by the current polarity input.
- R11: While `clk_en` and `tx_enable` are 1, `sclk` changes only in the cycle after a half tick.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| clk_en | input | 1 | Enables the clock pin and its pulses |
| pol_sel | input | 1 | Idle level select (0 low, 1 high) |
| pha_sel | input | 1 | Edge placement select |
| last_pulse_sel | input | 1 | 1 clocks the final data bit, 0 suppresses it |
| word9_sel | input | 1 | 0 gives 8 data bits, 1 gives 9 |
| tx_enable | input | 1 | Transmitter enabled; freezes the settings |
| half_tick | input | 1 | One-cycle tick at twice the bit rate |
| bit_go | input | 1 | Start of a bit; coincides with a half tick |
| bit_num | input | 4 | Index of the current bit: 0 start, 1..WL data, WL+1 stop |
| sclk | output | 1 | Serial clock pin level |
| sclk_oe | output | 1 | Serial clock pin output enable |
| frame_done | output | 1 | One-cycle strobe after the last data bit |

## Verification
Full frames are driven for every combination of enable, polarity, phase, last-pulse and word-length settings. At every half-tick position, the `sclk` level is compared with a value computed from the bit index and half position. This separates centre-first edge placement from start-first placement and separates suppressed final pulses from clocked ones. Pulse counts per frame confirm the 8 and 9 data-bit lengths. During each frame, every setting input is inverted; the unchanged waveform shows the settings are frozen, and the idle level seen after release shows the new values are taken up. The position of `frame_done` is checked in frames with and without a suppressed final pulse.

// File: rtl/sync_clk_pkg.sv
package sync_clk_pkg;

    typedef struct packed {
        logic pol;
        logic pha;
        logic lbcl;
        logic word9;
    } clk_cfg_t;

endpackage

// File: rtl/sync_clk_cfg.sv
module sync_clk_cfg
    import sync_clk_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  logic     tx_enable,
    input  clk_cfg_t cfg_in,
    output clk_cfg_t cfg_d,
    output clk_cfg_t cfg_q
);
    // Settings pass through while the transmitter is off, frozen while on.
    always_comb begin
        cfg_d = tx_enable ? cfg_q : cfg_in;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cfg_q <= cfg_in;
        else        cfg_q <= cfg_d;
    end
endmodule

// File: rtl/sync_clk_seq.sv
module sync_clk_seq
    import sync_clk_pkg::*;
#(
    parameter int BASE_BITS = 8,
    parameter int IDX_W     = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clk_en,
    input  logic             tx_enable,
    input  logic             half_tick,
    input  logic             bit_go,
    input  logic [IDX_W-1:0] bit_num,
    input  logic             pol_now,
    input  clk_cfg_t         cfg_d,
    input  clk_cfg_t         cfg_q,
    output logic             sclk,
    output logic             done
);
    typedef struct packed {
        logic track;
        logic half;
        logic mute;
        logic last;
        logic sclk;
        logic done;
    } seq_t;

    seq_t st_d, st_q;

    logic [IDX_W-1:0] wl;
    logic             is_data;
    logic             is_last;
    logic             idle;

    always_comb begin
        wl      = cfg_q.word9 ? IDX_W'(BASE_BITS + 1) : IDX_W'(BASE_BITS);
        is_data = (bit_num != '0) && (bit_num <= wl);
        is_last = (bit_num == wl);
        idle    = cfg_d.pol;

        st_d      = st_q;
        st_d.done = 1'b0;

        if (half_tick && tx_enable) begin
            if (st_q.track) begin
                if (!st_q.half) begin
                    // centre of the bit
                    st_d.half = 1'b1;
                    if (!st_q.mute) st_d.sclk = cfg_q.pha ? idle : ~idle;
                end else begin
                    // end of the bit
                    st_d.track = 1'b0;
                    st_d.sclk  = idle;
                    if (st_q.last) st_d.done = 1'b1;
                end
            end
            if (bit_go && is_data) begin
                st_d.track = 1'b1;
                st_d.half  = 1'b0;
                st_d.last  = is_last;
                st_d.mute  = is_last && !cfg_q.lbcl;
                st_d.sclk  = (cfg_q.pha && !st_d.mute) ? ~idle : idle;
            end
        end

        if (!tx_enable) begin
            st_d.track = 1'b0;
            st_d.sclk  = idle;
        end
        if (!clk_en) st_d.sclk = idle;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q      <= '0;
            st_q.sclk <= pol_now;
        end else begin
            st_q <= st_d;
        end
    end

    assign sclk = st_q.sclk;
    assign done = st_q.done;
endmodule

// File: rtl/sync_clk_gen.sv
module sync_clk_gen
    import sync_clk_pkg::*;
#(
    parameter int BASE_BITS = 8,
    localparam int IDX_W    = $clog2(BASE_BITS + 3)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clk_en,
    input  logic             pol_sel,
    input  logic             pha_sel,
    input  logic             last_pulse_sel,
    input  logic             word9_sel,
    input  logic             tx_enable,
    input  logic             half_tick,
    input  logic             bit_go,
    input  logic [IDX_W-1:0] bit_num,
    output logic             sclk,
    output logic             sclk_oe,
    output logic             frame_done
);
    clk_cfg_t cfg_in, cfg_d, cfg_q;

    assign cfg_in = '{pol: pol_sel, pha: pha_sel, lbcl: last_pulse_sel, word9: word9_sel};

    sync_clk_cfg u_cfg (
        .clk       (clk),
        .rst_n     (rst_n),
        .tx_enable (tx_enable),
        .cfg_in    (cfg_in),
        .cfg_d     (cfg_d),
        .cfg_q     (cfg_q)
    );

    sync_clk_seq #(.BASE_BITS(BASE_BITS), .IDX_W(IDX_W)) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .clk_en    (clk_en),
        .tx_enable (tx_enable),
        .half_tick (half_tick),
        .bit_go    (bit_go),
        .bit_num   (bit_num),
        .pol_now   (pol_sel),
        .cfg_d     (cfg_d),
        .cfg_q     (cfg_q),
        .sclk      (sclk),
        .done      (frame_done)
    );

    assign sclk_oe = clk_en;
endmodule

// File: rtl/sync_clk_gen_chk.sv
module sync_clk_gen_chk
    import sync_clk_pkg::*;
(
    input logic     clk,
    input logic     rst_n,
    input logic     clk_en,
    input logic     pol_sel,
    input logic     tx_enable,
    input logic     half_tick,
    input logic     sclk,
    input logic     frame_done,
    input clk_cfg_t cfg_q
);
    assert_idle_when_off_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (!clk_en && !tx_enable) |=> sclk == $past(pol_sel));

    assert_cfg_frozen_R8: assert property (@(posedge clk) disable iff (!rst_n)
        tx_enable |=> $stable(cfg_q));

    assert_tick_paced_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (clk_en && tx_enable && !half_tick) |=> $stable(sclk));

    assert_done_single_R9: assert property (@(posedge clk) disable iff (!rst_n)
        frame_done |=> !frame_done);
endmodule

bind sync_clk_gen sync_clk_gen_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .clk_en     (clk_en),
    .pol_sel    (pol_sel),
    .tx_enable  (tx_enable),
    .half_tick  (half_tick),
    .sclk       (sclk),
    .frame_done (frame_done),
    .cfg_q      (cfg_q)
);

// File: tb/sync_clk_gen_test.sv
module sync_clk_gen_test;
    localparam int HT = 4;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       clk_en = 1'b0, pol_sel = 1'b0, pha_sel = 1'b0;
    logic       last_pulse_sel = 1'b0, word9_sel = 1'b0, tx_enable = 1'b0;
    logic       half_tick = 1'b0, bit_go = 1'b0;
    logic [3:0] bit_num = '0;
    logic       sclk, sclk_oe, frame_done;

    int checks = 0;
    int errors = 0;
    int cycles = 0;
    bit done_flag = 1'b0;

    sync_clk_gen uut (
        .clk(clk), .rst_n(rst_n), .clk_en(clk_en), .pol_sel(pol_sel),
        .pha_sel(pha_sel), .last_pulse_sel(last_pulse_sel), .word9_sel(word9_sel),
        .tx_enable(tx_enable), .half_tick(half_tick), .bit_go(bit_go),
        .bit_num(bit_num), .sclk(sclk), .sclk_oe(sclk_oe), .frame_done(frame_done)
    );

    always #5 clk = ~clk;

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > 150000 && !done_flag) begin
            errors = errors + 1;
            checks = checks + 1;
            $display("FAIL watchdog: actual %0d cycles, expected completion", cycles);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic run_frame(input bit en, input bit pol, input bit pha,
                             input bit lb, input bit w9);
        int wl, exp_pulses, pulses, bad_wave, bad_done, first_bad_act, first_bad_exp;
        bit prev;
        wl = w9 ? 9 : 8;
        exp_pulses = en ? (lb ? wl : wl - 1) : 0;
        pulses = 0; bad_wave = 0; bad_done = 0;
        first_bad_act = 0; first_bad_exp = 0;
        prev = pol;
        // settings applied with the transmitter off
        @(negedge clk);
        clk_en = en; pol_sel = pol; pha_sel = pha; last_pulse_sel = lb; word9_sel = w9;
        tx_enable = 1'b0;
        @(negedge clk); @(negedge clk);
        check(sclk == pol, "R2 idle level before frame", sclk, pol);
        check(sclk_oe == en, "R1 output enable", sclk_oe, en);
        tx_enable = 1'b1;
        for (int b = 0; b <= wl + 1; b++) begin
            for (int h = 0; h < 2; h++) begin
                for (int k = 0; k < HT; k++) begin
                    half_tick = (k == 0);
                    bit_go    = (k == 0) && (h == 0);
                    bit_num   = 4'(b);
                    if (b == 1 && h == 0 && k == 0) begin
                        // inverted inputs must be ignored while enabled (R8)
                        pol_sel = ~pol; pha_sel = ~pha; last_pulse_sel = ~lb; word9_sel = ~w9;
                    end
                    @(negedge clk);
                    begin
                        bit clocked, act, exp_s, exp_d;
                        clocked = en && b >= 1 && b <= wl && !(b == wl && !lb);
                        act = pha ? (h == 0) : (h == 1);
                        exp_s = (clocked && act) ? ~pol : pol;
                        exp_d = (b == wl + 1) && (h == 0) && (k == 0);
                        if (sclk != exp_s) begin
                            if (bad_wave == 0) begin
                                first_bad_act = sclk; first_bad_exp = exp_s;
                            end
                            bad_wave++;
                        end
                        if (frame_done != exp_d) bad_done++;
                        if (prev == pol && sclk != pol) pulses++;
                        prev = sclk;
                    end
                end
            end
        end
        half_tick = 1'b0; bit_go = 1'b0; bit_num = '0;
        check(bad_wave == 0, pha ? "R4 R3 R6 R8 waveform (phase 1)" : "R3 R4 R6 R8 waveform (phase 0)",
              first_bad_act, first_bad_exp);
        check(pulses == exp_pulses, "R5 R6 R7 R1 pulse count", pulses, exp_pulses);
        check(bad_done == 0, "R9 frame_done placement", bad_done, 0);
        tx_enable = 1'b0;
        @(negedge clk);
        check(sclk == !pol, "R8 new idle level after release", sclk, !pol);
        pol_sel = pol;
        @(negedge clk);
        check(sclk == pol, "R2 idle restored", sclk, pol);
    endtask

    initial begin
        pol_sel = 1'b1;
        clk_en  = 1'b1;
        repeat (3) @(negedge clk);
        check(sclk == 1'b1, "R10 reset idle level high", sclk, 1);
        check(sclk_oe == 1'b1, "R1 oe during reset", sclk_oe, 1);
        check(frame_done == 1'b0, "R9 no strobe in reset", frame_done, 0);
        pol_sel = 1'b0;
        @(negedge clk);
        check(sclk == 1'b0, "R10 reset idle follows polarity", sclk, 0);
        rst_n = 1'b1;
        for (int c = 0; c < 32; c++) begin
            run_frame(c[4], c[0], c[1], c[2], c[3]);
        end
        done_flag = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule